// File: doc/BRIEF.md
# Multi-Function Pad Control Cell

This block is the control logic for a single external I/O pad. Software writes a 32-bit configuration word through a simple register port. The word picks which of eight internal peripheral functions owns the pad. The selected function drives the pad data and output enable, and it is the only function that receives the pad's input level. The word also sets where the pull resistors take their state from, the drive strength and slew code handed to the analog pad macro, and a separate low-power path. That path replaces the peripheral drive with two fixed bits while the system sleeps.

Each pad also carries an edge detector. The pad input first goes through a two-flop synchronizer. Rising edges, falling edges, or both can then set a sticky flag, which stays set until software asserts the clear bit or reset occurs. The flag is combined with an external per-peripheral wake enable to request a system wakeup. Sleep entry and exit come in on one level input. The switch between the run path and the sleep path is registered, so the output enable changes only on a clock edge.

Top module: `padmux_cell`

## Requirements
- R1: After synchronous reset the configuration reads 0x0000_0800: function 0, drive code 2 (fast 3 mA), all other bits 0. The edge flag is clear.
- R2: A write stores the data, and a read returns it, with bit 3 and bits 31:16 always reading 0 whatever was written (read mask 0x0000_FFF7).
- R3: Outside sleep override, pad data and output enable equal the data and enable of the peripheral numbered by bits 2:0.
- R4: The raw pad input appears only on the peripheral input numbered by bits 2:0. All other peripheral inputs are 0.
- R5: When the sleep input is high and bit 9 is 1, the pad is driven from the next clock edge with data = bit 8 and output enable = NOT bit 7. With bit 9 at 0 the function path stays in use during sleep. Leaving sleep returns the function path on the next clock edge.
- R6: When bit 15 is 1, pull-up = bit 14 and pull-down = bit 13. When bit 15 is 0, the pulls come from the selected peripheral's pull requests.
- R7: The drive code output always equals bits 12:10 (0 to 3 fast 1/2/3/4 mA, 4 slow 6 mA, 5 fast 6 mA, 6 slow 10 mA, 7 fast 10 mA).
- R8: With bit 4 set, a rising pad input sets the edge flag on the third rising clock edge after the input change. Bit 5 does the same for falling edges, and with both bits set either edge counts. With neither bit set no edge sets the flag.
- R9: The edge flag is sticky. While bit 6 is 1 the flag is cleared on the next clock edge and no edge sets it.
- R10: The wakeup request is high exactly when the edge flag and the wake enable input are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| sleep_req | input | 1 | High while the system is in low-power mode |
| fn_out | input | 8 | Data from each peripheral function |
| fn_oe | input | 8 | Output enable from each peripheral function |
| fn_pu | input | 8 | Pull-up request from each peripheral function |
| fn_pd | input | 8 | Pull-down request from each peripheral function |
| fn_in | output | 8 | Pad input routed to the selected function |
| pad_in | input | 1 | Level seen at the pad |
| pad_out | output | 1 | Data to the pad driver |
| pad_oe | output | 1 | Output enable to the pad driver |
| pad_pu | output | 1 | Pull-up enable |
| pad_pd | output | 1 | Pull-down enable |
| pad_drv | output | 3 | Drive strength and slew code |
| wake_en | input | 1 | Wake enable for the owning peripheral |
| edge_flag | output | 1 | Sticky edge-detected status |
| wake_req | output | 1 | Wakeup request |

## Verification
The assertions assume that the configuration is not rewritten in the cycle after the sleep path is engaged unless they can tell it changed, and that the pad input sits at 0 through reset, so the synchronizer starts from a known level. The bench holds the pad input low during reset. It changes the configuration only through whole write cycles, and it changes the pad input and the sleep level just after a clock edge. This keeps every synchronizer stage and the registered path select free of same-edge races.

// File: rtl/padmux_pkg.sv
`timescale 1ns/1ps
package padmux_pkg;

    localparam int NUM_FN  = 8;
    localparam int FN_W    = $clog2(NUM_FN);
    localparam int CFG_W   = 32;

    // configuration word layout (bit positions fixed by the software view)
    typedef struct packed {
        logic [15:0] rsvd_hi;     // 31:16
        logic        pull_own;    // 15
        logic        pu_en;       // 14
        logic        pd_en;       // 13
        logic [2:0]  drv;         // 12:10
        logic        slp_sel;     // 9
        logic        slp_data;    // 8
        logic        slp_oe_n;    // 7
        logic        edge_clr;    // 6
        logic        fall_en;     // 5
        logic        rise_en;     // 4
        logic        rsvd3;       // 3
        logic [2:0]  fn_sel;      // 2:0
    } pad_cfg_t;

    localparam logic [2:0]       DRV_FAST_3MA = 3'd2;
    localparam logic [CFG_W-1:0] CFG_MASK     = 32'h0000_FFF7;
    localparam logic [CFG_W-1:0] CFG_RESET    = {16'h0, 3'b000, DRV_FAST_3MA, 10'h000};

    typedef struct packed {
        logic dout;
        logic oe;
    } pad_drive_t;

    typedef enum logic { PATH_RUN = 1'b0, PATH_SLEEP = 1'b1 } path_e;

    function automatic pad_cfg_t cfg_sanitize(input logic [CFG_W-1:0] w);
        return pad_cfg_t'(w & CFG_MASK);
    endfunction

endpackage

// File: rtl/padmux_cfg_reg.sv
`timescale 1ns/1ps
module padmux_cfg_reg
    import padmux_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output pad_cfg_t         cfg,
    output logic [CFG_W-1:0] cfg_rdata
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= pad_cfg_t'(CFG_RESET);
        else if (cfg_we)
            cfg <= cfg_sanitize(cfg_wdata);
    end

    assign cfg_rdata = cfg;

    // R1: reset value visible right after reset release
    a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> cfg_rdata == CFG_RESET);

    // R2: a write is read back with reserved bits forced to zero
    a_r2_write_readback: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> cfg_rdata == ($past(cfg_wdata) & CFG_MASK));

endmodule

// File: rtl/padmux_route.sv
`timescale 1ns/1ps
module padmux_route
    import padmux_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pad_cfg_t          cfg,
    input  logic              sleep_req,
    input  logic [NUM_FN-1:0] fn_out,
    input  logic [NUM_FN-1:0] fn_oe,
    input  logic [NUM_FN-1:0] fn_pu,
    input  logic [NUM_FN-1:0] fn_pd,
    output logic [NUM_FN-1:0] fn_in,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              pad_pu,
    output logic              pad_pd,
    output logic [2:0]        pad_drv
);

    path_e      path_q;
    pad_drive_t run_drv;
    pad_drive_t slp_drv;
    pad_drive_t sel_drv;
    logic [FN_W-1:0] sel;

    assign sel = cfg.fn_sel[FN_W-1:0];

    // path select is registered so the enable only moves on a clock edge
    always_ff @(posedge clk) begin
        if (rst)
            path_q <= PATH_RUN;
        else
            path_q <= (sleep_req && cfg.slp_sel) ? PATH_SLEEP : PATH_RUN;
    end

    always_comb begin
        run_drv.dout = fn_out[sel];
        run_drv.oe   = fn_oe[sel];
        slp_drv.dout = cfg.slp_data;
        slp_drv.oe   = ~cfg.slp_oe_n;
        sel_drv      = (path_q == PATH_SLEEP) ? slp_drv : run_drv;
    end

    assign pad_out = sel_drv.dout;
    assign pad_oe  = sel_drv.oe;
    assign pad_pu  = cfg.pull_own ? cfg.pu_en : fn_pu[sel];
    assign pad_pd  = cfg.pull_own ? cfg.pd_en : fn_pd[sel];
    assign pad_drv = cfg.drv;

    for (genvar g = 0; g < NUM_FN; g++) begin : g_in_route
        assign fn_in[g] = (sel == FN_W'(g)) ? pad_in : 1'b0;
    end

    // R4: at most one peripheral ever sees the pad input
    a_r4_in_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fn_in));

    // R5: sleep override drives the fixed bits one edge after entry
    a_r5_sleep_override: assert property (@(posedge clk) disable iff (rst)
        (sleep_req && cfg.slp_sel) |=>
            (!$stable(cfg) || (pad_out == cfg.slp_data && pad_oe == !cfg.slp_oe_n)));

endmodule

// File: rtl/padmux_edge.sv
`timescale 1ns/1ps
module padmux_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pad_in,
    input  logic rise_en,
    input  logic fall_en,
    input  logic edge_clr,
    output logic edge_flag
);

    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] shift_q;
    logic            cur, prev, hit;

    always_ff @(posedge clk) begin
        if (rst)
            shift_q <= '0;
        else
            shift_q <= {shift_q[SH_W-2:0], pad_in};
    end

    assign cur  = shift_q[SYNC_STAGES-1];
    assign prev = shift_q[SYNC_STAGES];
    assign hit  = (rise_en && cur && !prev) || (fall_en && !cur && prev);

    always_ff @(posedge clk) begin
        if (rst)
            edge_flag <= 1'b0;
        else if (edge_clr)
            edge_flag <= 1'b0;
        else if (hit)
            edge_flag <= 1'b1;
    end

    // R9: flag holds until cleared
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (edge_flag && !edge_clr) |=> edge_flag);

    // R9: clear bit empties the flag on the next edge
    a_r9_flag_clear: assert property (@(posedge clk) disable iff (rst)
        edge_clr |=> !edge_flag);

    // R8: flag only rises while some edge kind is enabled
    a_r8_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(edge_flag) |-> $past(rise_en || fall_en));

endmodule

// File: rtl/padmux_cell.sv
`timescale 1ns/1ps
module padmux_cell
    import padmux_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              sleep_req,
    input  logic [NUM_FN-1:0] fn_out,
    input  logic [NUM_FN-1:0] fn_oe,
    input  logic [NUM_FN-1:0] fn_pu,
    input  logic [NUM_FN-1:0] fn_pd,
    output logic [NUM_FN-1:0] fn_in,
    input  logic              pad_in,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              pad_pu,
    output logic              pad_pd,
    output logic [2:0]        pad_drv,
    input  logic              wake_en,
    output logic              edge_flag,
    output logic              wake_req
);

    pad_cfg_t cfg;

    padmux_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg),
        .cfg_rdata (cfg_rdata)
    );

    padmux_route u_route (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .sleep_req (sleep_req),
        .fn_out    (fn_out),
        .fn_oe     (fn_oe),
        .fn_pu     (fn_pu),
        .fn_pd     (fn_pd),
        .fn_in     (fn_in),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .pad_pu    (pad_pu),
        .pad_pd    (pad_pd),
        .pad_drv   (pad_drv)
    );

    padmux_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst       (rst),
        .pad_in    (pad_in),
        .rise_en   (cfg.rise_en),
        .fall_en   (cfg.fall_en),
        .edge_clr  (cfg.edge_clr),
        .edge_flag (edge_flag)
    );

    assign wake_req = edge_flag && wake_en;

    // R10: no wakeup request without a latched edge
    a_r10_wake_needs_flag: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (edge_flag && wake_en));

endmodule

// File: tb/tb_padmux_cell.sv
`timescale 1ns/1ps
module tb_padmux_cell;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        sleep_req = 1'b0;
    logic [7:0]  fn_out = '0, fn_oe = '0, fn_pu = '0, fn_pd = '0;
    logic [7:0]  fn_in;
    logic        pad_in = 1'b0;
    logic        pad_out, pad_oe, pad_pu, pad_pd;
    logic [2:0]  pad_drv;
    logic        wake_en = 1'b0;
    logic        edge_flag, wake_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    padmux_cell dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sleep_req(sleep_req), .fn_out(fn_out),
        .fn_oe(fn_oe), .fn_pu(fn_pu), .fn_pd(fn_pd), .fn_in(fn_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .pad_pd(pad_pd), .pad_drv(pad_drv), .wake_en(wake_en),
        .edge_flag(edge_flag), .wake_req(wake_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [31:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic clear_flag();
        wr(32'h0000_0840);
        tick();
        check("R9 flag cleared", {31'd0, edge_flag}, 32'd0);
        wr(32'h0000_0800);
    endtask

    task automatic t_reset();
        check("R1 reset cfg", cfg_rdata, 32'h0000_0800);
        check("R1 reset flag", {31'd0, edge_flag}, 32'd0);
        check("R7 reset drive", {29'd0, pad_drv}, 32'd2);
    endtask

    task automatic t_regs();
        wr(32'hFFFF_FFFF);
        check("R2 all ones masked", cfg_rdata, 32'h0000_FFF7);
        wr(32'h1234_5678);
        check("R2 pattern masked", cfg_rdata, 32'h0000_5670);
        wr(32'h0000_0800);
        check("R2 restore", cfg_rdata, 32'h0000_0800);
    endtask

    task automatic t_fn_route();
        logic [7:0] pats [2] = '{8'hA5, 8'h3C};
        foreach (pats[p]) begin
            fn_out = pats[p];
            fn_oe  = ~pats[p];
            for (int f = 0; f < 8; f++) begin
                wr(32'h0000_0800 | f);
                check("R3 pad_out", {31'd0, pad_out}, {31'd0, pats[p][f]});
                check("R3 pad_oe", {31'd0, pad_oe}, {31'd0, ~pats[p][f]});
            end
        end
    endtask

    task automatic t_pad_in();
        wr(32'h0000_0805);
        pad_in = 1'b1; #1;
        check("R4 fn_in sel5 high", {24'd0, fn_in}, 32'h20);
        pad_in = 1'b0; #1;
        check("R4 fn_in sel5 low", {24'd0, fn_in}, 32'h00);
        wr(32'h0000_0802);
        pad_in = 1'b1; #1;
        check("R4 fn_in sel2 high", {24'd0, fn_in}, 32'h04);
        tick(); tick(); tick();
        pad_in = 1'b0;
        tick(); tick(); tick();
    endtask

    task automatic t_pull();
        fn_pu = 8'hA5; fn_pd = 8'h5A;
        wr(32'h0000_0800);
        check("R6 fn pu sel0", {30'd0, pad_pu, pad_pd}, 32'b10);
        wr(32'h0000_0801);
        check("R6 fn pu sel1", {30'd0, pad_pu, pad_pd}, 32'b01);
        wr(32'h0000_C801);
        check("R6 own pull-up", {30'd0, pad_pu, pad_pd}, 32'b10);
        wr(32'h0000_A800);
        check("R6 own pull-down", {30'd0, pad_pu, pad_pd}, 32'b01);
    endtask

    task automatic t_drive();
        for (int d = 0; d < 8; d++) begin
            wr(32'(d) << 10);
            check("R7 drive code", {29'd0, pad_drv}, 32'(d));
        end
        wr(32'h0000_0800);
    endtask

    task automatic t_sleep();
        fn_out = 8'h00; fn_oe = 8'h00;
        wr(32'h0000_0B03);          // fn 3, sleep select, data 1, oe_n 0
        sleep_req = 1'b1; #1;
        check("R5 run path before edge", {30'd0, pad_out, pad_oe}, 32'b00);
        tick();
        check("R5 sleep path", {30'd0, pad_out, pad_oe}, 32'b11);
        wr(32'h0000_0B83);          // oe_n 1
        check("R5 sleep oe off", {30'd0, pad_out, pad_oe}, 32'b10);
        wr(32'h0000_0803);          // select bit off while asleep
        tick();
        check("R5 sel off keeps fn", {30'd0, pad_out, pad_oe}, 32'b00);
        wr(32'h0000_0B03);
        tick();
        check("R5 re-enter", {30'd0, pad_out, pad_oe}, 32'b11);
        sleep_req = 1'b0; #1;
        check("R5 exit not before edge", {30'd0, pad_out, pad_oe}, 32'b11);
        tick();
        check("R5 exit returns fn", {30'd0, pad_out, pad_oe}, 32'b00);
        wr(32'h0000_0800);
    endtask

    task automatic t_edge_rise();
        clear_flag();
        wr(32'h0000_0810);
        pad_in = 1'b1;
        tick(); tick();
        check("R8 rise not before 3rd edge", {31'd0, edge_flag}, 32'd0);
        tick();
        check("R8 rise on 3rd edge", {31'd0, edge_flag}, 32'd1);
        pad_in = 1'b0;
        tick(); tick(); tick(); tick();
        check("R9 sticky after input low", {31'd0, edge_flag}, 32'd1);
    endtask

    task automatic t_edge_fall();
        clear_flag();
        wr(32'h0000_0820);
        pad_in = 1'b1;
        tick(); tick(); tick(); tick();
        check("R8 fall ignores rise", {31'd0, edge_flag}, 32'd0);
        pad_in = 1'b0;
        tick(); tick(); tick();
        check("R8 fall detected", {31'd0, edge_flag}, 32'd1);
    endtask

    task automatic t_edge_both();
        clear_flag();
        pad_in = 1'b1;
        tick(); tick(); tick(); tick();
        wr(32'h0000_0830);
        pad_in = 1'b0;
        tick(); tick(); tick();
        check("R8 both catches fall", {31'd0, edge_flag}, 32'd1);
        clear_flag();
        wr(32'h0000_0830);
        pad_in = 1'b1;
        tick(); tick(); tick();
        check("R8 both catches rise", {31'd0, edge_flag}, 32'd1);
        pad_in = 1'b0;
        tick(); tick(); tick(); tick();
    endtask

    task automatic t_edge_none();
        clear_flag();
        pad_in = 1'b1;
        tick(); tick(); tick(); tick();
        pad_in = 1'b0;
        tick(); tick(); tick(); tick();
        check("R8 no enable no flag", {31'd0, edge_flag}, 32'd0);
    endtask

    task automatic t_clear_blocks();
        wr(32'h0000_0870);          // both enables with clear held
        pad_in = 1'b1;
        tick(); tick(); tick(); tick();
        check("R9 clear blocks rise", {31'd0, edge_flag}, 32'd0);
        pad_in = 1'b0;
        tick(); tick(); tick(); tick();
        check("R9 clear blocks fall", {31'd0, edge_flag}, 32'd0);
        wr(32'h0000_0830);
        tick(); tick();
        check("R9 no stale edge after clear", {31'd0, edge_flag}, 32'd0);
    endtask

    task automatic t_wake();
        clear_flag();
        wake_en = 1'b1; #1;
        check("R10 no flag no wake", {31'd0, wake_req}, 32'd0);
        wr(32'h0000_0810);
        pad_in = 1'b1;
        tick(); tick(); tick();
        check("R10 wake with flag and enable", {31'd0, wake_req}, 32'd1);
        wake_en = 1'b0; #1;
        check("R10 enable low no wake", {31'd0, wake_req}, 32'd0);
        pad_in = 1'b0;
        tick(); tick(); tick(); tick();
    endtask

    initial begin
        tick(); tick(); tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_regs();
        t_fn_route();
        t_pad_in();
        t_pull();
        t_drive();
        t_sleep();
        t_edge_rise();
        t_edge_fall();
        t_edge_both();
        t_edge_none();
        t_clear_blocks();
        t_wake();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule